// File: doc/BRIEF.md
# USB Default Control Endpoint Handshake Controller

This block holds the control byte of a USB device's default control endpoint and decides the handshake for every token the host sends to that endpoint. A CPU writes and reads the byte through an 8-bit register port. The byte carries four fields: a data sequence bit, a force-stall bit, transmit and receive enables, and a transmit byte count.

A token decoder upstream presents each decoded IN, OUT or SETUP token with a valid strobe. The buffer logic reports whether the transmit buffer and the receive buffer are full. One clock after each token strobe, the block issues a registered decision: send or accept, NAK, or STALL. With that decision it gives the data PID for IN data and the byte count to send. Serial encoding, CRC and the buffer memories are outside the block.

The data toggle belongs to software alone. The hardware never flips it. The only field that hardware changes is the stall bit, which a SETUP token clears.

Top module: `uep0_hs_ctrl`

## Requirements
- R1: A register write stores the byte in these positions: bit 7 is the sequence bit, bit 6 is force stall, bit 5 is transmit enable, bit 4 is receive enable, and bits 3:0 are the transmit byte count. The read port always shows the current byte, including any stall clear made by hardware.
- R2: For every decision, hs_data1 equals the sequence bit (0 = DATA0, 1 = DATA1) and hs_count equals bits 3:0. A count of 0 on a send decision is passed through unchanged and means a zero-length packet.
- R3: Tokens never change the sequence bit. Only a register write changes it.
- R4: While force stall is 1, an IN or OUT token gets decision code 2'b10 (STALL), whatever the enables and full flags are.
- R5: A SETUP token (tok_kind 2'b11) always gets code 2'b00 and clears the force-stall bit.
- R6: An IN token (tok_kind 2'b01) without stall gets code 2'b01 (NAK) when transmit enable is 0 or tx_full is 1. Otherwise it gets 2'b00.
- R7: An OUT token (tok_kind 2'b10) without stall gets code 2'b01 when receive enable is 0 or rx_full is 1. Otherwise it gets 2'b00.
- R8: Reset clears the whole control byte and hs_valid.
- R9: hs_valid is a one-cycle pulse in the cycle after a strobed token. A strobe with tok_kind 2'b00 produces no pulse and changes no state.
- R10: When a register write and a SETUP token arrive in the same cycle, the stall bit ends at 0 and the other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Current control byte |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | 01 IN, 10 OUT, 11 SETUP, 00 none |
| tx_full | input | 1 | Transmit buffer full |
| rx_full | input | 1 | Receive buffer full |
| hs_valid | output | 1 | Decision valid pulse |
| hs_code | output | 2 | 00 send/accept, 01 NAK, 10 STALL |
| hs_data1 | output | 1 | PID for IN data: 1 = DATA1 |
| hs_count | output | 4 | Transmit byte count |

## Verification
A table sends IN and OUT tokens under each combination that decides the answer: enable off, buffer full, stall with and without the enables, and the clean case. This separates the NAK causes from one another and shows that STALL wins over NAK. After each token the byte is read back, which shows whether a token disturbed the sequence bit or the stall bit. Directed cases then cover a SETUP arriving together with a write, a strobe with no token kind, a zero byte count, the single-cycle valid pulse, and reset in the middle of activity.

// File: rtl/uep0_pkg.sv
package uep0_pkg;
  typedef enum logic [1:0] {
    TOK_NONE  = 2'b00,
    TOK_IN    = 2'b01,
    TOK_OUT   = 2'b10,
    TOK_SETUP = 2'b11
  } tok_kind_t;

  typedef enum logic [1:0] {
    HS_GO    = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_code_t;
endpackage

// File: rtl/uep0_ctrl_reg.sv
module uep0_ctrl_reg #(
  parameter int CNT_W = 4,
  localparam int BYTE_W = CNT_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stall_clr,
  output logic [BYTE_W-1:0] ctrl_q
);
  localparam int STALL_B = BYTE_W - 2;
  localparam int SEQ_B   = BYTE_W - 1;

  logic [BYTE_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data;
    if (stall_clr) ctrl_d[STALL_B] = 1'b0;   // hardware clear wins over write
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> ctrl_q == '0); // R8
  AST_SEQ_SW_ONLY: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ctrl_q[SEQ_B] == $past(ctrl_q[SEQ_B])); // R3
  AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stall_clr |=> !ctrl_q[STALL_B]); // R5
  AST_WRITE_WITH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && stall_clr) |=> ctrl_q[SEQ_B] == $past(wr_data[SEQ_B])); // R10
endmodule

// File: rtl/uep0_decide.sv
module uep0_decide
  import uep0_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int BYTE_W = CNT_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [BYTE_W-1:0] ctrl,
  input  logic              tx_full,
  input  logic              rx_full,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              hs_data1,
  output logic [CNT_W-1:0]  hs_count
);
  localparam int SEQ_B   = BYTE_W - 1;
  localparam int STALL_B = BYTE_W - 2;
  localparam int TXEN_B  = BYTE_W - 3;
  localparam int RXEN_B  = BYTE_W - 4;

  logic     tok_live;
  hs_code_t code_d;

  assign tok_live = tok_valid && (tok_kind != TOK_NONE);

  always_comb begin
    code_d = HS_GO;
    unique case (tok_kind)
      TOK_IN: begin
        if (ctrl[STALL_B])                  code_d = HS_STALL;
        else if (!ctrl[TXEN_B] || tx_full)  code_d = HS_NAK;
      end
      TOK_OUT: begin
        if (ctrl[STALL_B])                  code_d = HS_STALL;
        else if (!ctrl[RXEN_B] || rx_full)  code_d = HS_NAK;
      end
      default: code_d = HS_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_GO;
      hs_data1 <= 1'b0;
      hs_count <= '0;
    end else begin
      hs_valid <= tok_live;
      if (tok_live) begin
        hs_code  <= code_d;
        hs_data1 <= ctrl[SEQ_B];
        hs_count <= ctrl[CNT_W-1:0];
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    tok_live |=> hs_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !tok_live |=> !hs_valid); // R9
  AST_STALL_WINS: assert property (@(posedge clk) disable iff (rst)
    (tok_live && tok_kind != TOK_SETUP && ctrl[STALL_B]) |=> hs_code == HS_STALL); // R4
  AST_SETUP_GO: assert property (@(posedge clk) disable iff (rst)
    (tok_live && tok_kind == TOK_SETUP) |=> hs_code == HS_GO); // R5
  AST_PID_TRACKS: assert property (@(posedge clk) disable iff (rst)
    tok_live |=> hs_data1 == $past(ctrl[SEQ_B])); // R2
endmodule

// File: rtl/uep0_hs_ctrl.sv
module uep0_hs_ctrl
  import uep0_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int BYTE_W = CNT_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic              tx_full,
  input  logic              rx_full,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              hs_data1,
  output logic [CNT_W-1:0]  hs_count
);
  logic [BYTE_W-1:0] ctrl_q;
  logic              setup_seen;

  assign setup_seen = tok_valid && (tok_kind == TOK_SETUP);
  assign reg_rdata  = ctrl_q;

  uep0_ctrl_reg #(.CNT_W(CNT_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .wr_data   (reg_wdata),
    .stall_clr (setup_seen),
    .ctrl_q    (ctrl_q)
  );

  uep0_decide #(.CNT_W(CNT_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .ctrl      (ctrl_q),
    .tx_full   (tx_full),
    .rx_full   (rx_full),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code),
    .hs_data1  (hs_data1),
    .hs_count  (hs_count)
  );

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> hs_code != 2'b11); // R9
endmodule

// File: tb/sim_uep0_hs_ctrl.sv
module sim_uep0_hs_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {ctrl[15:8], kind[7:6], tx_full[5], rx_full[4], 2'b00, code[1:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h25, 2'b01, 1'b0, 1'b0, 2'b00, 2'b00},  // R6 clean IN
    {8'hA3, 2'b01, 1'b0, 1'b0, 2'b00, 2'b00},  // R2 DATA1
    {8'h05, 2'b01, 1'b0, 1'b0, 2'b00, 2'b01},  // R6 txen off
    {8'h25, 2'b01, 1'b1, 1'b0, 2'b00, 2'b01},  // R6 tx full
    {8'h65, 2'b01, 1'b0, 1'b0, 2'b00, 2'b10},  // R4 stall
    {8'h40, 2'b01, 1'b1, 1'b0, 2'b00, 2'b10},  // R4 stall beats NAK
    {8'h10, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00},  // R7 clean OUT
    {8'h00, 2'b10, 1'b0, 1'b0, 2'b00, 2'b01},  // R7 rxen off
    {8'h10, 2'b10, 1'b0, 1'b1, 2'b00, 2'b01},  // R7 rx full
    {8'h50, 2'b10, 1'b0, 1'b1, 2'b00, 2'b10},  // R4 stall on OUT
    {8'hC0, 2'b11, 1'b1, 1'b1, 2'b00, 2'b00},  // R5 SETUP
    {8'h20, 2'b01, 1'b0, 1'b0, 2'b00, 2'b00}   // R2 zero length
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tok_valid = 1'b0;
  logic [1:0] tok_kind = '0;
  logic tx_full = 1'b0, rx_full = 1'b0;
  logic hs_valid, hs_data1;
  logic [1:0] hs_code;
  logic [3:0] hs_count;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uep0_hs_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tok_valid(tok_valid), .tok_kind(tok_kind), .tx_full(tx_full), .rx_full(rx_full),
    .hs_valid(hs_valid), .hs_code(hs_code), .hs_data1(hs_data1), .hs_count(hs_count)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // drives a token for one cycle; returns at the negedge where the decision is visible
  task automatic tok(input logic [1:0] k, input logic tf, input logic rf);
    tok_valid = 1'b1; tok_kind = k; tx_full = tf; rx_full = rf;
    @(negedge clk);
    tok_valid = 1'b0; tok_kind = 2'b00; tx_full = 1'b0; rx_full = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] c, exp_rd;
    repeat (3) @(negedge clk);
    chk("R8 reset byte", reg_rdata, 8'h00);
    chk("R8 reset valid", {7'b0, hs_valid}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      c = VEC[i][15:8];
      wr(c);
      chk("R1 readback", reg_rdata, c);
      tok(VEC[i][7:6], VEC[i][5], VEC[i][4]);
      chk("R9 valid pulse", {7'b0, hs_valid}, 8'h01);
      chk("R4 R5 R6 R7 code", {6'b0, hs_code}, {6'b0, VEC[i][1:0]});
      chk("R2 pid", {7'b0, hs_data1}, {7'b0, c[7]});
      chk("R2 count", {4'b0, hs_count}, {4'b0, c[3:0]});
      exp_rd = (VEC[i][7:6] == 2'b11) ? (c & 8'hBF) : c;
      chk("R3 R5 byte after token", reg_rdata, exp_rd);
      @(negedge clk);
      chk("R9 single pulse", {7'b0, hs_valid}, 8'h00);
    end

    // R10: write together with SETUP
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'hF7;
    tok(2'b11, 1'b0, 1'b0);
    reg_wr = 1'b0;
    chk("R10 write+setup", reg_rdata, 8'hB7);
    chk("R5 setup go", {6'b0, hs_code}, 8'h00);

    // R9: strobe with no token kind
    wr(8'hE9);
    @(negedge clk);
    tok(2'b00, 1'b0, 1'b0);
    chk("R9 kind none no pulse", {7'b0, hs_valid}, 8'h00);
    chk("R9 kind none no change", reg_rdata, 8'hE9);

    // R3: stall IN and OUT leave sequence bit alone
    tok(2'b01, 1'b0, 1'b0);
    chk("R4 stall IN", {6'b0, hs_code}, 8'h02);
    tok(2'b10, 1'b0, 1'b0);
    chk("R3 seq kept", reg_rdata, 8'hE9);

    // R8: reset mid-activity
    rst = 1'b1;
    tok(2'b01, 1'b0, 1'b0);
    chk("R8 reset clears byte", reg_rdata, 8'h00);
    chk("R8 reset clears valid", {7'b0, hs_valid}, 8'h00);
    rst = 1'b0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule